// File: doc/BRIEF.md
# Splittable Performance Counter Bank

The block is a bank of event counters for performance monitoring, reached through a simple memory-mapped register port with a 64-bit data word. It holds four physical counters. Each one counts either as a single 32-bit counter or as two independent 16-bit halves, so up to eight logical counters are visible. A per-counter mode bit in a global control register selects the width at run time.

Software never writes a live counter directly. A counter write lands in a holding latch for that counter, and the latched value reaches the live counter only when the control register is written with its enable bit set. That write also commits pending values when the bank is already running. Wraps from all-ones to zero set sticky bits in a status register. A read of that register returns the bits and clears them in the same access, and a write to it loads the interrupt mask. The interrupt output is high while any masked status bit is set.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every counter, latch, the control register, the status register and the interrupt mask read as zero, and `irq` is low.
- R2: Each register is 32 bits wide and sits in bus bits [63:32]. Bus bits [31:0] are ignored on writes and read as zero. Word address 0 is control, word address 1 is status, and word address 8+i is logical counter i (i = 0..7).
- R3: Control bit p (bus bit 32+p, p = 0..3) selects split mode for physical counter p. Control bit 31 (bus bit 63) is the global enable. A counter advances by one on each clock in which its event input is high, and only while the enable bit is set.
- R4: A write to a counter register changes only that counter's holding latch. The value read back does not change until the latch is committed.
- R5: A control write with bit 31 set copies every pending latch value into its live counter. This holds when the bank is already enabled.
- R6: In split mode the upper half counts event input p and the lower half counts event input p+4. Neither half carries into the other. Logical counter p reads the upper half and logical counter p+4 reads the lower half, each zero-extended.
- R7: A write to logical counter p (p < 4) loads the full 32-bit latch in 32-bit mode, or only the upper-half latch in split mode. A write to logical counter p+4 always loads only the lower-half latch, also in 32-bit mode.
- R8: A wrap from all-ones to zero sets a sticky status bit. In 32-bit mode or for an upper half this is bit p; for a lower half it is bit p+4 (bus bit 32+n for status bit n).
- R9: A status read returns the pending bits and clears them. A wrap in the same cycle as the read stays set for the next read.
- R10: A status write loads the 8-bit interrupt mask from bus bits [39:32]. `irq` is high exactly when a status bit and its mask bit are both set. Writing zero keeps `irq` low.
- R11: When a commit and an event meet in the same cycle, a counter with a pending latch value takes the latch value and drops that cycle's event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (needed for read-to-clear of status) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 64 | Write data, register in bits [63:32] |
| bus_rdata | output | 64 | Read data for bus_addr, register in bits [63:32] |
| evt | input | 8 | Event inputs: bit p counts physical p (full or upper), bit p+4 counts the lower half of p |
| irq | output | 1 | Masked OR of the status bits |

## Verification
A wrong pending flag or latch half shows at the first counter read after a commit, which returns a stale or merged value. A missing priority rule shows as one count too many on the counter that was committed while its event was high. A carry between halves or a wrong overflow bit shows within a cycle of the wrap, either in the split readback or in the status word and `irq`. A lost or stale status bit shows on the next status read, because clearing is tied to that read.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int unsigned CTL_WORD  = 0;
  localparam int unsigned STAT_WORD = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/perf_rst_sync.sv
module perf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/perf_phys_ctr.sv
module perf_phys_ctr #(
  parameter int unsigned CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split,
  input  logic             run,
  input  logic             evt_hi,
  input  logic             evt_lo,
  input  logic             wr_full,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [CTR_W-1:0] wdata,
  input  logic             commit,
  output logic [CTR_W-1:0] cnt,
  output logic             ovf_hi,
  output logic             ovf_lo
);
  localparam int unsigned HW = CTR_W / 2;

  logic [CTR_W-1:0] cnt_q, cnt_n, latch_q, latch_n;
  logic             pend_hi_q, pend_hi_n, pend_lo_q, pend_lo_n;
  logic             take, upd_en;

  assign take = commit & (pend_hi_q | pend_lo_q);

  always_comb begin
    cnt_n     = cnt_q;
    latch_n   = latch_q;
    pend_hi_n = pend_hi_q;
    pend_lo_n = pend_lo_q;
    ovf_hi    = 1'b0;
    ovf_lo    = 1'b0;
    if (wr_full) begin
      latch_n   = wdata;
      pend_hi_n = 1'b1;
      pend_lo_n = 1'b1;
    end
    if (wr_hi) begin
      latch_n[CTR_W-1:HW] = wdata[HW-1:0];
      pend_hi_n           = 1'b1;
    end
    if (wr_lo) begin
      latch_n[HW-1:0] = wdata[HW-1:0];
      pend_lo_n       = 1'b1;
    end
    if (take) begin
      if (pend_hi_q) cnt_n[CTR_W-1:HW] = latch_q[CTR_W-1:HW];
      if (pend_lo_q) cnt_n[HW-1:0]     = latch_q[HW-1:0];
      pend_hi_n = 1'b0;
      pend_lo_n = 1'b0;
    end else if (run) begin
      if (split) begin
        if (evt_hi) begin
          cnt_n[CTR_W-1:HW] = cnt_q[CTR_W-1:HW] + 1'b1;
          ovf_hi            = &cnt_q[CTR_W-1:HW];
        end
        if (evt_lo) begin
          cnt_n[HW-1:0] = cnt_q[HW-1:0] + 1'b1;
          ovf_lo        = &cnt_q[HW-1:0];
        end
      end else if (evt_hi) begin
        cnt_n  = cnt_q + 1'b1;
        ovf_hi = &cnt_q;
      end
    end
  end

  assign upd_en = wr_full | wr_hi | wr_lo | take | (run & (evt_hi | evt_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      latch_q   <= '0;
      pend_hi_q <= 1'b0;
      pend_lo_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q     <= cnt_n;
      latch_q   <= latch_n;
      pend_hi_q <= pend_hi_n;
      pend_lo_q <= pend_lo_n;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/perf_status.sv
module perf_status #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] ovf,
  input  logic             rd_clr,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_d,
  output logic [NBITS-1:0] status,
  output logic             irq
);
  logic [NBITS-1:0] stat_q, stat_n, mask_q, mask_n;
  logic             stat_en;

  always_comb begin
    stat_n = (rd_clr ? '0 : stat_q) | ovf;
    mask_n = mask_we ? mask_d : mask_q;
  end

  assign stat_en = rd_clr | (|ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_n;
    end
  end

  assign status = stat_q;
  assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter  int unsigned NUM_PHYS = 4,
  parameter  int unsigned CTR_W    = 32,
  localparam int unsigned NLOG     = 2 * NUM_PHYS,
  localparam int unsigned ADDR_W   = $clog2(2 * NLOG),
  localparam int unsigned BUS_W    = 2 * CTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NLOG-1:0]   evt,
  output logic              irq
);
  import perf_pkg::*;

  localparam int unsigned HW     = CTR_W / 2;
  localparam int unsigned EN_BIT = CTR_W - 1;

  logic                      rst_n_s;
  logic [CTR_W-1:0]          wdat;
  logic                      unused_low;
  reg_sel_e                  sel;
  logic [ADDR_W-1:0]         off;
  logic                      commit;
  logic                      ctl_en_q, ctl_en_n, ctl_we;
  logic [NUM_PHYS-1:0]       split_q, split_n;
  logic [CTR_W-1:0]          cnt_q [NUM_PHYS];
  logic [NUM_PHYS*CTR_W-1:0] cnt_flat;
  logic [NLOG-1:0]           ovf;
  logic [NLOG-1:0]           stat_q;
  logic [CTR_W-1:0]          rd_reg;

  perf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign wdat       = bus_wdata[BUS_W-1:CTR_W];
  assign unused_low = ^bus_wdata[CTR_W-1:0];
  assign off        = bus_addr - ADDR_W'(NLOG);

  always_comb begin
    if (bus_addr == ADDR_W'(CTL_WORD))       sel = SEL_CTL;
    else if (bus_addr == ADDR_W'(STAT_WORD)) sel = SEL_STAT;
    else if (bus_addr >= ADDR_W'(NLOG))      sel = SEL_CTR;
    else                                     sel = SEL_NONE;
  end

  // Control register: next state and register kept apart
  assign ctl_we = bus_we & (sel == SEL_CTL);
  assign commit = ctl_we & wdat[EN_BIT];

  always_comb begin
    ctl_en_n = ctl_en_q;
    split_n  = split_q;
    if (ctl_we) begin
      ctl_en_n = wdat[EN_BIT];
      split_n  = wdat[NUM_PHYS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_en_q <= 1'b0;
      split_q  <= '0;
    end else if (ctl_we) begin
      ctl_en_q <= ctl_en_n;
      split_q  <= split_n;
    end
  end

  // Physical counters
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
    logic wr_any_ctr;
    logic wr_full, wr_hi, wr_lo;
    assign wr_any_ctr = bus_we & (sel == SEL_CTR);
    assign wr_full    = wr_any_ctr & (off == ADDR_W'(p)) & ~split_q[p];
    assign wr_hi      = wr_any_ctr & (off == ADDR_W'(p)) &  split_q[p];
    assign wr_lo      = wr_any_ctr & (off == ADDR_W'(p + NUM_PHYS));

    perf_phys_ctr #(.CTR_W(CTR_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .split  (split_q[p]),
      .run    (ctl_en_q),
      .evt_hi (evt[p]),
      .evt_lo (evt[p + NUM_PHYS]),
      .wr_full(wr_full),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .wdata  (wdat),
      .commit (commit),
      .cnt    (cnt_q[p]),
      .ovf_hi (ovf[p]),
      .ovf_lo (ovf[p + NUM_PHYS])
    );

    assign cnt_flat[p*CTR_W +: CTR_W] = cnt_q[p];
  end

  // Status and interrupt
  perf_status #(.NBITS(NLOG)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ovf    (ovf),
    .rd_clr (bus_re & (sel == SEL_STAT)),
    .mask_we(bus_we & (sel == SEL_STAT)),
    .mask_d (wdat[NLOG-1:0]),
    .status (stat_q),
    .irq    (irq)
  );

  // Read mux
  always_comb begin
    rd_reg = '0;
    unique case (sel)
      SEL_CTL: begin
        rd_reg[EN_BIT]       = ctl_en_q;
        rd_reg[NUM_PHYS-1:0] = split_q;
      end
      SEL_STAT: rd_reg[NLOG-1:0] = stat_q;
      SEL_CTR: begin
        for (int l = 0; l < int'(NLOG); l++) begin
          if (off == ADDR_W'(l)) begin
            if (l < int'(NUM_PHYS)) begin
              if (split_q[l]) rd_reg[HW-1:0] = cnt_q[l][CTR_W-1:HW];
              else            rd_reg         = cnt_q[l];
            end else begin
              rd_reg[HW-1:0] = cnt_q[l - int'(NUM_PHYS)][HW-1:0];
            end
          end
        end
      end
      default: rd_reg = '0;
    endcase
  end

  assign bus_rdata = {rd_reg, {CTR_W{1'b0}}};
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter  int unsigned NUM_PHYS = 4,
  parameter  int unsigned CTR_W    = 32,
  localparam int unsigned NLOG     = 2 * NUM_PHYS,
  localparam int unsigned ADDR_W   = $clog2(2 * NLOG),
  localparam int unsigned BUS_W    = 2 * CTR_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic                      bus_re,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [BUS_W-1:0]          bus_wdata,
  input logic [BUS_W-1:0]          bus_rdata,
  input logic [NLOG-1:0]           evt,
  input logic                      irq,
  input logic                      ctl_en,
  input logic [NUM_PHYS*CTR_W-1:0] cnt_flat,
  input logic [NLOG-1:0]           status
);
  logic stat_rd, stat_wr;
  assign stat_rd = bus_re & (bus_addr == ADDR_W'(1));
  assign stat_wr = bus_we & (bus_addr == ADDR_W'(1));

  AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[CTR_W-1:0] == '0); // R2

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !bus_we) |=> $stable(cnt_flat)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status))); // R8

  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == '0) |=> status == '0); // R9

  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[BUS_W-1:CTR_W] == '0) |=> !irq); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != '0); // R10
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NUM_PHYS(NUM_PHYS), .CTR_W(CTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .evt      (evt),
  .irq      (irq),
  .ctl_en   (ctl_en_q),
  .cnt_flat (cnt_flat),
  .status   (stat_q)
);

// File: tb/perf_ctr_bank_tb.sv
module perf_ctr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_re;
  logic [3:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic [7:0]  evt;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [3:0] A_CTL  = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [31:0] EN    = 32'h8000_0000;

  always #2 clk = ~clk;

  perf_ctr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = {d, 32'hDEAD_BEEF};
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata[63:32];
    chk("R2 low half", {32'h0, bus_rdata[31:0]}, 64'h0);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] m, input int n);
    @(negedge clk);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTL, d);  chk("R1 control", {32'h0, d}, 64'h0);
    rd(A_STAT, d); chk("R1 status", {32'h0, d}, 64'h0);
    rd(4'd8, d);   chk("R1 counter0", {32'h0, d}, 64'h0);
    rd(4'd13, d);  chk("R1 counter5", {32'h0, d}, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(A_CTL, 32'h0000_0005);
    rd(A_CTL, d); chk("R3 split bits readback", {32'h0, d}, 64'h5);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_CTL; bus_wdata = 64'h0000_0000_FFFF_FFFF;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_CTL, d); chk("R2 lower write bits ignored", {32'h0, d}, 64'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    wr(4'd8, 32'h1234_5678);
    rd(4'd8, d); chk("R4 latch only", {32'h0, d}, 64'h0);
    wr(A_CTL, EN);
    rd(4'd8, d); chk("R5 commit on enable", {32'h0, d}, 64'h1234_5678);
    wr(4'd9, 32'hAAAA_0000);
    rd(4'd9, d); chk("R4 latch while enabled", {32'h0, d}, 64'h0);
    wr(A_CTL, EN);
    rd(4'd9, d); chk("R5 recommit while enabled", {32'h0, d}, 64'hAAAA_0000);
  endtask

  task automatic t_count();
    logic [31:0] d;
    pulse_evt(8'h02, 10);
    rd(4'd9, d); chk("R3 counts while enabled", {32'h0, d}, 64'hAAAA_000A);
    wr(A_CTL, 32'h0);
    pulse_evt(8'h02, 5);
    rd(4'd9, d); chk("R3 holds while disabled", {32'h0, d}, 64'hAAAA_000A);
    wr(A_CTL, EN);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk); evt = 8'h01;
    wr(4'd8, 32'h0001_0100);
    wr(A_CTL, EN);
    evt = '0;
    rd(4'd8, d); chk("R11 commit beats event", {32'h0, d}, 64'h0001_0100);
    wr(4'd12, 32'h0000_BEEF);
    wr(A_CTL, EN);
    rd(4'd8, d);  chk("R7 lower-half write in 32-bit mode", {32'h0, d}, 64'h0001_BEEF);
    rd(4'd12, d); chk("R7 logical 4 reads lower half", {32'h0, d}, 64'h0000_BEEF);
  endtask

  task automatic t_split();
    logic [31:0] d;
    wr(A_CTL, 32'h0000_0004);
    wr(4'd10, 32'h0000_FFFE);
    wr(4'd14, 32'h0000_FFFD);
    wr(A_CTL, EN | 32'h4);
    rd(4'd10, d); chk("R6 upper half readback", {32'h0, d}, 64'hFFFE);
    rd(4'd14, d); chk("R7 lower half latch", {32'h0, d}, 64'hFFFD);
    pulse_evt(8'h44, 4);
    rd(4'd10, d); chk("R6 upper wraps without carry", {32'h0, d}, 64'h2);
    rd(4'd14, d); chk("R6 lower independent", {32'h0, d}, 64'h1);
    rd(A_STAT, d); chk("R8 half overflow bits", {32'h0, d}, 64'h44);
    rd(A_STAT, d); chk("R9 cleared by read", {32'h0, d}, 64'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_STAT, 32'h0000_0004);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(A_CTL, EN | 32'h4);
    pulse_evt(8'h08, 1);
    chk("R10 unmasked bit gives no irq", {63'h0, irq}, 64'h0);
    wr(A_STAT, 32'h0000_0008);
    chk("R10 masked bit raises irq", {63'h0, irq}, 64'h1);
    wr(A_STAT, 32'h0);
    chk("R10 zero mask drops irq", {63'h0, irq}, 64'h0);
    rd(A_STAT, d); chk("R8 32-bit wrap sets bit p", {32'h0, d}, 64'h8);
    rd(4'd11, d);  chk("R8 counter wrapped to zero", {32'h0, d}, 64'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(4'd11, 32'hFFFF_FFFF);
    wr(A_CTL, EN | 32'h4);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = A_STAT; evt = 8'h08;
    #1;
    chk("R9 read before wrap", {32'h0, bus_rdata[63:32]}, 64'h0);
    @(negedge clk);
    bus_re = 1'b0; evt = '0;
    rd(A_STAT, d); chk("R9 wrap during clear survives", {32'h0, d}, 64'h8);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lanes();
    t_latch();
    t_count();
    t_priority();
    t_split();
    t_irq();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule